// File: doc/BRIEF.md
# Frame Check Sequence Engine with Self-Test Answer

This block computes a 16-bit frame check sequence over a stream of bytes, one byte per register write. Software clears the engine through a control register, writes each byte into an input register, and then reads back both the number of bytes taken and the 16-bit result. The input count lets driver code confirm that no write was lost. A short, fixed four-byte sequence with a known result lets start-up code confirm that the engine works before real traffic depends on it.

The check uses the reflected form of the polynomial x^16+x^12+x^5+1. It shifts least-significant bit first, starts from all ones and complements its output. Each write is absorbed in a single clock. The result register always reflects the current state, so no read has any side effect. The register port is a plain write strobe with address and data, plus a combinational read mux.

Top module: `crc_frame_engine`

## Requirements
- R1: After the asynchronous reset, the count reads 0 and the result reads 0x0000, which is the complemented all-ones preset.
- R2: A write to address 0 with bit 15 set returns the checksum state to its preset and the count to 0. Both are visible on the next read.
- R3: A write to address 0 with bit 15 clear changes neither the count nor the result. Clock cycles with no write change neither.
- R4: Reading address 0 returns the count in bits 11:0 and zero in bits 15:12.
- R5: A write to address 1 feeds only bits 7:0 into the checksum. Bits 15:8 of that write have no effect on the result.
- R6: Each write to address 1 adds one to the count. The count stops at 0xFFF and stays there.
- R7: Each byte updates the state as follows, for its bits from bit 0 upward. XOR the bit into state bit 0. Shift the state right by one. If the bit that was shifted out was 1, XOR in 0x8408. The result read at address 2 is the bitwise complement of the state.
- R8: After a clear and the bytes 0xCC, 0xF5, 0xF1 and 0xA7, the count reads 4 and the result reads 0x51DF.
- R9: A write takes effect at the clock edge that samples it. The updated values appear on the read port in the following cycle.
- R10: Reading addresses 1 and 3 returns zero. No read changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write address: 0 control, 1 byte input |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 control/count, 2 result, others zero |
| rd_data | output | 16 | Combinational read data |

## Verification
A corrupted checksum bit shows up at the result address in the cycle after the byte that caused it. It stays there for every later byte, because each step folds the whole state forward. A wrong count shows up at the control address in the very next cycle. A saturation fault shows up only after 4095 writes, so the bench drives the count that far. Sweeping every byte value from the preset state exposes any single wrong feedback tap at once.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 2'd0,
    ADR_INPUT  = 2'd1,
    ADR_RESULT = 2'd2,
    ADR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int unsigned       CRC_W  = 16,
  parameter int unsigned       BYTE_W = 8,
  parameter logic [CRC_W-1:0]  POLY_R = 16'h8408
) (
  input  logic [CRC_W-1:0]  state_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  state_o
);
  logic [CRC_W-1:0] acc [BYTE_W+1];

  assign acc[0] = state_i;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic fb;
    assign fb         = acc[b][0] ^ byte_i[b];
    assign acc[b + 1] = (acc[b] >> 1) ^ (fb ? POLY_R : '0);
  end

  assign state_o = acc[BYTE_W];
endmodule

// File: rtl/crc_sat_counter.sv
module crc_sat_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i & (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/crc_reg_decode.sv
module crc_reg_decode
  import crc_pkg::*;
#(
  parameter int unsigned CLR_BIT = 15,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned CRC_W   = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CRC_W-1:0]  result_i,
  output logic              clr_o,
  output logic              feed_o,
  output logic [REG_W-1:0]  rd_data
);
  always_comb begin
    clr_o  = wr_en && (reg_addr_e'(wr_addr) == ADR_CTRL) && wr_data[CLR_BIT];
    feed_o = wr_en && (reg_addr_e'(wr_addr) == ADR_INPUT);
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_addr_e'(rd_addr))
      ADR_CTRL:   rd_data[CNT_W-1:0] = cnt_i;
      ADR_RESULT: rd_data[CRC_W-1:0] = result_i;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/crc_frame_engine.sv
module crc_frame_engine
  import crc_pkg::*;
#(
  parameter int unsigned      CRC_W   = 16,
  parameter int unsigned      CNT_W   = 12,
  parameter int unsigned      IN_W    = 12,
  parameter int unsigned      BYTE_W  = 8,
  parameter int unsigned      CLR_BIT = 15,
  parameter logic [CRC_W-1:0] POLY_R  = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET  = 16'hFFFF,
  parameter logic [CRC_W-1:0] XOROUT  = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic              clr, feed, crc_en;
  logic [IN_W-1:0]   in_masked;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_step;
  logic [CNT_W-1:0]  cnt;

  crc_reg_decode #(.CLR_BIT(CLR_BIT), .CNT_W(CNT_W), .CRC_W(CRC_W)) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .cnt_i    (cnt),
    .result_i (crc_q ^ XOROUT),
    .clr_o    (clr),
    .feed_o   (feed),
    .rd_data  (rd_data)
  );

  assign in_masked = wr_data[IN_W-1:0];

  crc_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY_R(POLY_R)) u_step (
    .state_i (crc_q),
    .byte_i  (in_masked[BYTE_W-1:0]),
    .state_o (crc_step)
  );

  crc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .inc_i (feed),
    .cnt_o (cnt)
  );

  always_comb begin
    crc_en = clr | feed;
    crc_d  = clr ? PRESET : crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= PRESET;
    else if (crc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/crc_frame_engine_chk.sv
module crc_frame_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic [1:0]  rd_addr,
  input logic [15:0] rd_data,
  input logic [15:0] crc_q,
  input logic [11:0] cnt
);
  logic do_clr, do_feed;
  assign do_clr  = wr_en && wr_addr == 2'd0 && wr_data[15];
  assign do_feed = wr_en && wr_addr == 2'd1;

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (cnt == 12'd0 && crc_q == 16'hFFFF));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_clr && !do_feed) |=> ($stable(cnt) && $stable(crc_q)));

  assert_ctrl_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[15:12] == 4'd0));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_feed && cnt != 12'hFFF) |=> (cnt == $past(cnt) + 12'd1));

  assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_feed && cnt == 12'hFFF) |=> (cnt == 12'hFFF));

  assert_spare_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[0]) |-> (rd_data == 16'd0));
endmodule

bind crc_frame_engine crc_frame_engine_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .crc_q   (crc_q),
  .cnt     (cnt)
);

// File: tb/crc_frame_engine_tb_top.sv
module crc_frame_engine_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [15:0] model;
  int          mcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] step(input logic [15:0] s, input logic [7:0] b);
    logic [15:0] r = s;
    for (int i = 0; i < 8; i++) begin
      logic lsb = r[0] ^ b[i];
      r = r >> 1;
      if (lsb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    if (a == 2'd1) begin
      model = step(model, d[7:0]);
      if (mcnt < 4095) mcnt++;
    end else if (d[15]) begin
      model = 16'hFFFF; mcnt = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic expect_state(input string req);
    logic [15:0] v;
    rd(2'd0, v); check(req, v, 16'(mcnt));
    rd(2'd2, v); check(req, v, ~model);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [15:0] lfsr;
    model = 16'hFFFF; mcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1", v, 16'h0000);
    rd(2'd2, v); check("R1", v, 16'h0000);

    // R8 known answer, R9 one-cycle visibility
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h00CC); expect_state("R9");
    wr(2'd1, 16'h00F5);
    wr(2'd1, 16'h00F1);
    wr(2'd1, 16'h00A7);
    rd(2'd0, v); check("R8", v, 16'd4);
    rd(2'd2, v); check("R8", v, 16'h51DF);

    // R10 spare addresses read zero; reading twice does not disturb state
    rd(2'd1, v); check("R10", v, 16'h0000);
    rd(2'd3, v); check("R10", v, 16'h0000);
    rd(2'd2, v); rd(2'd2, v); check("R10", v, 16'h51DF);

    // R3 control write without clear bit, and idle cycles
    wr(2'd0, 16'h7FFF); expect_state("R3");
    repeat (5) @(negedge clk);
    expect_state("R3");

    // R2 clear
    wr(2'd0, 16'h8000);
    rd(2'd0, v); check("R2", v, 16'h0000);
    rd(2'd2, v); check("R2", v, 16'h0000);

    // R5 and R7: every byte from preset, upper bits noisy
    for (int b = 0; b < 256; b++) begin
      wr(2'd0, 16'h8000);
      wr(2'd1, {8'(b * 37 + 5), 8'(b)});
      rd(2'd2, v); check("R7", v, ~step(16'hFFFF, 8'(b)));
    end

    // R5 upper bits ignored: same byte, differing upper bits, same result
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'hFF5A);
    rd(2'd2, v); check("R5", v, ~step(16'hFFFF, 8'h5A));

    // R7 long chained stream
    wr(2'd0, 16'h8000);
    lfsr = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr(2'd1, lfsr);
      expect_state("R7");
    end

    // R6 saturation and R4 upper control bits
    wr(2'd0, 16'h8000);
    for (int i = 0; i < 4094; i++) wr(2'd1, 16'(i));
    rd(2'd0, v); check("R6", v, 16'h0FFE);
    wr(2'd1, 16'h0011);
    rd(2'd0, v); check("R6", v, 16'h0FFF);
    wr(2'd1, 16'h0022);
    wr(2'd1, 16'h0033);
    rd(2'd0, v); check("R4", v & 16'hF000, 16'h0000);
    expect_state("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule